// File: doc/BRIEF.md
# Carrier Oscillator with Double-Buffered Tuning

This block is a numerically controlled oscillator. It produces a quadrature pair of 18-bit sine and cosine samples. A 32-bit phase accumulator grows each enabled clock by the sum of the active frequency word and a serially loaded frequency offset. A 10-bit phase offset is added to the top of the accumulated phase. The top 18 bits of that sum address a sine/cosine table. The table is built at elaboration from a quarter-wave table with 256 entries, and symmetry rebuilds the other three quadrants.

Software writes the frequency and phase-offset words into holding registers. A holding value reaches the oscillator only when it is committed. A commit happens through a write to a dedicated commit address. It can also happen through a sync pulse, which moves both words in the same clock when sync is enabled. If the clear option is set, the accumulator feedback is forced to zero on any commit clock. Several units that share the sync pin can therefore start from the same phase.

The samples flow out with a valid flag and no ready. The oscillator never stalls, so the consumer must take every sample for which `o_valid` is high. There is no back-pressure.

Top module: `nco_dbuf_top`

## Requirements
- R1: While `rst_n` is low, `sin_o`, `cos_o` and `o_valid` are 0. All holding, active, offset and accumulator state is 0.
- R2: On a clock where `ce` is 1, the accumulator becomes its old value plus the active frequency plus the serial offset, modulo 2^32. With `ce` at 0 it holds its value, unless R8 applies.
- R3: The phase address is the top 18 accumulator bits plus the active 10-bit phase offset placed in the top 10 of those 18 bits, modulo 2^18. An offset of 32 adds 11.25 degrees and 0x200 (-512) adds 180 degrees.
- R4: Let j be the top 10 bits of the phase address. `sin_o` equals round(131071*sin(2*pi*(j+0.5)/1024)) within 1 LSB, as signed two's complement. `cos_o` is the same expression at (j+256) mod 1024.
- R5: A write to address 1 (frequency holding register, all 32 bits) or to address 2 (phase holding register, bits 9:0) does not change the outputs until a commit.
- R6: A write to address 3 copies the frequency holding register to the active frequency. A write to address 4 copies the phase holding register to the active offset. The data on such a write is ignored, and each commit moves only its own word.
- R7: Address 0 holds the control word: bit 0 enables sync, bit 1 enables clear, and bits 3:2 select the serial word width. When bit 0 is 1, a high `sync_in` commits both words in the same clock. When bit 0 is 0, `sync_in` has no effect.
- R8: When control bit 1 is 1, on any clock where a commit of either kind occurs, the accumulator is loaded with 0 plus the increment (if `ce` is 1) or with 0 (if `ce` is 0). Without the bit, commits leave the accumulator path unchanged.
- R9: A serial offset word starts with `ser_sync` high for one clock. Its bits then follow on `ser_bit`, MSB first, one per clock, and there are 8, 16, 24 or 32 bits for width code 0, 1, 2 or 3. The word is left-aligned into the 32-bit offset, with zero lower bits. It takes effect on the edge that samples its last bit. A new `ser_sync` restarts reception.
- R10: The phase-to-output latency is 2 clocks. `o_valid` after edge k equals `ce` sampled at edge k-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce | input | 1 | Accumulator advance enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0 control, 1 frequency, 2 phase, 3 commit frequency, 4 commit phase) |
| wr_data | input | 32 | Register write data |
| sync_in | input | 1 | Commit pulse for both holding registers |
| ser_sync | input | 1 | Serial offset word start marker |
| ser_bit | input | 1 | Serial offset data, MSB first |
| sin_o | output | 18 | Sine sample, signed |
| cos_o | output | 18 | Cosine sample, signed |
| o_valid | output | 1 | Sample follows an enabled accumulator step |

## Verification
The checker assumes that a commit write and a sync pulse may coincide, and that holding writes never carry a commit. Both conditions hold because the address decode is one-hot by construction. The checker also assumes `ser_sync` is a single-clock pulse. The bench drives every input on the falling edge and keeps `ser_sync` to one clock. It sends serial words of every width, including one restarted mid-word. The reference model predicts each sample from the requirements alone, so it exercises sync with the enable on and off and clears together with both commit kinds.

// File: rtl/nco_pkg.sv
package nco_pkg;
  typedef struct packed {
    logic [1:0] wsel;
    logic       clr_en;
    logic       sync_en;
  } nco_ctl_t;

  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_CTL      = 3'd0;
  localparam logic [ADDR_W-1:0] A_FREQ     = 3'd1;
  localparam logic [ADDR_W-1:0] A_POFF     = 3'd2;
  localparam logic [ADDR_W-1:0] A_COMMIT_F = 3'd3;
  localparam logic [ADDR_W-1:0] A_COMMIT_P = 3'd4;
endpackage

// File: rtl/nco_regs.sv
module nco_regs
  import nco_pkg::*;
#(
  parameter int ACC_W  = 32,
  parameter int POFF_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [ACC_W-1:0]  wr_data,
  input  logic              sync_in,
  output nco_ctl_t          ctl,
  output logic [ACC_W-1:0]  freq_hold,
  output logic [ACC_W-1:0]  freq_act,
  output logic [POFF_W-1:0] poff_hold,
  output logic [POFF_W-1:0] poff_act,
  output logic              xfer_clr
);
  logic sync_go, f_go, p_go;

  assign sync_go  = sync_in && ctl.sync_en;
  assign f_go     = (wr_en && wr_addr == A_COMMIT_F) || sync_go;
  assign p_go     = (wr_en && wr_addr == A_COMMIT_P) || sync_go;
  assign xfer_clr = ctl.clr_en && (f_go || p_go);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl       <= '0;
      freq_hold <= '0;
      freq_act  <= '0;
      poff_hold <= '0;
      poff_act  <= '0;
    end else begin
      if (wr_en && wr_addr == A_CTL)  ctl       <= nco_ctl_t'(wr_data[3:0]);
      if (wr_en && wr_addr == A_FREQ) freq_hold <= wr_data;
      if (wr_en && wr_addr == A_POFF) poff_hold <= wr_data[POFF_W-1:0];
      if (f_go) freq_act <= freq_hold;
      if (p_go) poff_act <= poff_hold;
    end
  end
endmodule

// File: rtl/nco_serial.sv
module nco_serial #(
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       wsel,
  input  logic             ser_sync,
  input  logic             ser_bit,
  output logic [ACC_W-1:0] foff
);
  localparam int SEG   = ACC_W / 4;
  localparam int CNT_W = $clog2(ACC_W + 1);

  logic [CNT_W-1:0] cnt;
  logic [ACC_W-1:0] sh, sh_nxt;
  logic [CNT_W-1:0] nbits;
  logic [1:0]       wlat;

  assign sh_nxt = {sh[ACC_W-2:0], ser_bit};
  assign nbits  = CNT_W'((int'(wsel) + 1) * SEG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      sh   <= '0;
      foff <= '0;
      wlat <= '0;
    end else if (ser_sync) begin
      cnt  <= nbits;
      sh   <= '0;
      wlat <= wsel;
    end else if (cnt != '0) begin
      sh  <= sh_nxt;
      cnt <= cnt - 1'b1;
      if (cnt == CNT_W'(1))
        foff <= sh_nxt << ((3 - int'(wlat)) * SEG);
    end
  end
endmodule

// File: rtl/nco_phase.sv
module nco_phase #(
  parameter int ACC_W  = 32,
  parameter int PH_W   = 18,
  parameter int POFF_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic              clr,
  input  logic [ACC_W-1:0]  freq_act,
  input  logic [ACC_W-1:0]  foff,
  input  logic [POFF_W-1:0] poff_act,
  output logic [ACC_W-1:0]  acc,
  output logic [ACC_W-1:0]  inc,
  output logic [PH_W-1:0]   ph_r
);
  localparam int PAD = PH_W - POFF_W;

  logic [ACC_W-1:0] base;
  logic [PH_W-1:0]  ph_sum;

  assign inc    = freq_act + foff;
  assign base   = clr ? '0 : acc;
  assign ph_sum = acc[ACC_W-1 -: PH_W] + {poff_act, {PAD{1'b0}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc  <= '0;
      ph_r <= '0;
    end else begin
      acc  <= ce ? base + inc : base;
      ph_r <= ph_sum;
    end
  end
endmodule

// File: rtl/nco_sincos.sv
module nco_sincos #(
  parameter int PH_W  = 18,
  parameter int AMP_W = 18,
  parameter int QBITS = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [PH_W-1:0]         ph,
  output logic signed [AMP_W-1:0] sin_o,
  output logic signed [AMP_W-1:0] cos_o
);
  localparam int QDEPTH = 1 << QBITS;
  localparam int IDX_W  = QBITS + 2;
  localparam int AMPMAX = (1 << (AMP_W - 1)) - 1;

  function automatic int qval(input int k);
    real x, x2, t, s;
    x  = 1.5707963267948966 * (real'(k) + 0.5) / real'(QDEPTH);
    x2 = x * x;
    t  = x;
    s  = x;
    for (int n = 1; n < 8; n++) begin
      t = -t * x2 / real'((2 * n) * (2 * n + 1));
      s = s + t;
    end
    return $rtoi(s * real'(AMPMAX) + 0.5);
  endfunction

  logic [AMP_W-2:0] qtab [QDEPTH];

  for (genvar k = 0; k < QDEPTH; k++) begin : g_qtab
    localparam int V = qval(k);
    assign qtab[k] = V[AMP_W-2:0];
  end

  function automatic logic signed [AMP_W-1:0] rebuild(input logic [IDX_W-1:0] idx,
                                                      input logic [AMP_W-2:0] mag);
    logic signed [AMP_W-1:0] m;
    m = $signed({1'b0, mag});
    return idx[IDX_W-1] ? -m : m;
  endfunction

  function automatic logic [QBITS-1:0] fold(input logic [IDX_W-1:0] idx);
    return idx[QBITS] ? ~idx[QBITS-1:0] : idx[QBITS-1:0];
  endfunction

  logic [IDX_W-1:0] s_idx, c_idx;
  logic signed [AMP_W-1:0] s_val, c_val;

  always_comb begin
    s_idx = ph[PH_W-1 -: IDX_W];
    c_idx = s_idx + IDX_W'(QDEPTH);
    s_val = rebuild(s_idx, qtab[fold(s_idx)]);
    c_val = rebuild(c_idx, qtab[fold(c_idx)]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sin_o <= '0;
      cos_o <= '0;
    end else begin
      sin_o <= s_val;
      cos_o <= c_val;
    end
  end
endmodule

// File: rtl/nco_dbuf_top.sv
module nco_dbuf_top
  import nco_pkg::*;
#(
  parameter int ACC_W  = 32,
  parameter int PH_W   = 18,
  parameter int POFF_W = 10,
  parameter int AMP_W  = 18,
  parameter int QBITS  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ce,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [ACC_W-1:0]        wr_data,
  input  logic                    sync_in,
  input  logic                    ser_sync,
  input  logic                    ser_bit,
  output logic signed [AMP_W-1:0] sin_o,
  output logic signed [AMP_W-1:0] cos_o,
  output logic                    o_valid
);
  nco_ctl_t          ctl;
  logic [ACC_W-1:0]  freq_hold, freq_act, foff, acc, inc;
  logic [POFF_W-1:0] poff_hold, poff_act;
  logic              xfer_clr;
  logic [PH_W-1:0]   ph_r;
  logic              v_mid;

  nco_regs #(.ACC_W(ACC_W), .POFF_W(POFF_W)) u_regs (
    .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .sync_in,
    .ctl, .freq_hold, .freq_act, .poff_hold, .poff_act, .xfer_clr
  );

  nco_serial #(.ACC_W(ACC_W)) u_ser (
    .clk, .rst_n, .wsel(ctl.wsel), .ser_sync, .ser_bit, .foff
  );

  nco_phase #(.ACC_W(ACC_W), .PH_W(PH_W), .POFF_W(POFF_W)) u_ph (
    .clk, .rst_n, .ce, .clr(xfer_clr), .freq_act, .foff, .poff_act,
    .acc, .inc, .ph_r
  );

  nco_sincos #(.PH_W(PH_W), .AMP_W(AMP_W), .QBITS(QBITS)) u_tab (
    .clk, .rst_n, .ph(ph_r), .sin_o, .cos_o
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_mid   <= 1'b0;
      o_valid <= 1'b0;
    end else begin
      v_mid   <= ce;
      o_valid <= v_mid;
    end
  end
endmodule

// File: rtl/nco_dbuf_chk.sv
module nco_dbuf_chk #(
  parameter int ACC_W  = 32,
  parameter int POFF_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce,
  input logic              wr_en,
  input logic [2:0]        wr_addr,
  input logic              sync_in,
  input logic              sync_en,
  input logic              xfer_clr,
  input logic [ACC_W-1:0]  acc,
  input logic [ACC_W-1:0]  inc,
  input logic [ACC_W-1:0]  freq_hold,
  input logic [ACC_W-1:0]  freq_act,
  input logic [POFF_W-1:0] poff_act,
  input logic              o_valid
);
  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age <= '0;
    else if (age != 2'd3) age <= age + 1'b1;
  end

  // R10
  valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2) |-> (o_valid == $past(ce, 2)));

  // R2
  acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce && !xfer_clr) |=> $stable(acc));

  // R8
  acc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_clr && ce) |=> (acc == $past(inc)));

  // R6
  freq_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 3'd3) |=> (freq_act == $past(freq_hold)));

  // R7
  sync_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_in && !sync_en && !wr_en) |=> ($stable(freq_act) && $stable(poff_act)));
endmodule

bind nco_dbuf_top nco_dbuf_chk #(.ACC_W(ACC_W), .POFF_W(POFF_W)) u_chk (
  .clk, .rst_n, .ce, .wr_en, .wr_addr, .sync_in,
  .sync_en(ctl.sync_en), .xfer_clr, .acc, .inc,
  .freq_hold, .freq_act, .poff_act, .o_valid
);

// File: tb/tb_nco_dbuf_top.sv
module tb_nco_dbuf_top;
  logic clk = 0, rst_n = 0, ce = 0, wr_en = 0, sync_in = 0, ser_sync = 0, ser_bit = 0;
  logic [2:0]  wr_addr = 0;
  logic [31:0] wr_data = 0;
  logic signed [17:0] sin_o, cos_o;
  logic o_valid;

  nco_dbuf_top dut (.*);

  always #2 clk = ~clk;

  int errors = 0, checks = 0;
  string cur_req = "R1";
  int cycles = 0;

  // reference model state
  longint m_acc, m_fh, m_fa, m_foff, m_sh;
  int m_ph, m_ph2, m_pa, m_pha, m_sin, m_cos, m_v1, m_v2, m_cnt, m_wl;
  int m_sen, m_cen, m_wsel;

  function automatic int amp(input int j);
    real v;
    v = 131071.0 * $sin(2.0 * 3.14159265358979 * (real'(j) + 0.5) / 1024.0);
    return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
  endfunction

  task automatic model_reset();
    m_acc = 0; m_fh = 0; m_fa = 0; m_foff = 0; m_sh = 0;
    m_ph = 0; m_pa = 0; m_pha = 0; m_sin = 0; m_cos = 0; m_v1 = 0; m_v2 = 0;
    m_cnt = 0; m_wl = 0; m_sen = 0; m_cen = 0; m_wsel = 0; m_ph2 = 0;
  endtask

  initial model_reset();

  always @(posedge clk) begin
    if (rst_n) begin
      automatic int j = m_ph >> 8;
      automatic bit fgo, pgo, clr;
      automatic longint base, nbits;
      m_sin = amp(j);
      m_cos = amp((j + 256) % 1024);
      m_v2 = m_v1; m_v1 = ce;
      m_ph = int'(((m_acc >> 14) + (longint'(m_pha) << 8)) % 262144);
      fgo = (wr_en && wr_addr == 3) || (sync_in && m_sen != 0);
      pgo = (wr_en && wr_addr == 4) || (sync_in && m_sen != 0);
      clr = (m_cen != 0) && (fgo || pgo);
      base = clr ? 0 : m_acc;
      m_acc = ce ? (base + m_fa + m_foff) % 64'h1_0000_0000 : base;
      if (fgo) m_fa = m_fh;
      if (pgo) m_pha = m_pa;
      if (ser_sync) begin
        m_cnt = (m_wsel + 1) * 8; m_sh = 0; m_wl = m_wsel;
      end else if (m_cnt > 0) begin
        m_sh = m_sh * 2 + ser_bit;
        if (m_cnt == 1) m_foff = (m_sh << ((3 - m_wl) * 8)) % 64'h1_0000_0000;
        m_cnt--;
      end
      if (wr_en && wr_addr == 0) begin
        m_sen = wr_data[0]; m_cen = wr_data[1]; m_wsel = wr_data[3:2];
      end
      if (wr_en && wr_addr == 1) m_fh = wr_data;
      if (wr_en && wr_addr == 2) m_pa = wr_data[9:0];
    end
  end

  task automatic check_int(input string req, input string what, input int act, input int exp, input int tol);
    checks++;
    if (act - exp > tol || exp - act > tol) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n && cycles > 0) begin
      check_int(cur_req, "sin", int'(sin_o), m_sin, 1);
      check_int(cur_req, "cos", int'(cos_o), m_cos, 1);
      check_int("R10", "valid", int'(o_valid), m_v2, 0);
    end
    cycles++;
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0; wr_data = 32'hDEAD_BEEF;
  endtask

  task automatic ser_send(input logic [31:0] w, input int nb, input int cut);
    @(negedge clk);
    ser_sync = 1;
    @(negedge clk);
    ser_sync = 0;
    for (int i = 0; i < nb && i < cut; i++) begin
      ser_bit = w[nb - 1 - i];
      @(negedge clk);
    end
    ser_bit = 0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R1: reset state
    idle(3);
    check_int("R1", "sin in reset", int'(sin_o), 0, 0);
    check_int("R1", "cos in reset", int'(cos_o), 0, 0);
    check_int("R1", "valid in reset", int'(o_valid), 0, 0);
    rst_n = 1;
    idle(2);

    // R3 / R4: phase offset 32 then -512 with zero frequency
    cur_req = "R3";
    wr(2, 32); wr(4, 0); idle(3);
    check_int("R3", "sin at +11.25deg", int'(sin_o), amp(32), 1);
    check_int("R4", "cos at +11.25deg", int'(cos_o), amp(288), 1);
    wr(2, 32'h200); wr(4, 32'h1234); idle(3);
    check_int("R3", "sin at 180deg", int'(sin_o), amp(512), 1);

    // R5: holding writes do not move outputs
    cur_req = "R5";
    wr(1, 32'h0123_4567); wr(2, 32'h0AB); idle(6);
    check_int("R5", "sin unchanged before commit", int'(sin_o), amp(512), 1);

    // R2 / R6: commit frequency only, run, then pause
    cur_req = "R6";
    wr(3, 32'hFFFF_FFFF);
    cur_req = "R2";
    ce = 1; idle(40);
    ce = 0; idle(8);
    ce = 1; idle(5);
    cur_req = "R6";
    wr(4, 0); idle(10);

    // R7: sync disabled then enabled
    cur_req = "R7";
    wr(1, 32'h0400_0000); wr(2, 32'h155);
    @(negedge clk); sync_in = 1; @(negedge clk); sync_in = 0;
    idle(6);
    wr(0, 32'h1);
    @(negedge clk); sync_in = 1; @(negedge clk); sync_in = 0;
    idle(10);

    // R8: clear on sync and on both commit kinds
    cur_req = "R8";
    wr(0, 32'h3); wr(1, 32'h0200_0000);
    @(negedge clk); sync_in = 1; @(negedge clk); sync_in = 0;
    idle(6);
    wr(3, 0); idle(5);
    ce = 0; wr(4, 0); idle(4); ce = 1;
    wr(0, 32'h0); wr(3, 0); idle(5);

    // R9: serial offsets of each width, and a restarted word
    cur_req = "R9";
    wr(1, 0); wr(3, 0);
    for (int w = 0; w < 4; w++) begin
      wr(0, w << 2);
      ser_send(32'hA5C3_96E1 >> (24 - 8 * w), 8 * (w + 1), 99);
      idle(12);
    end
    wr(0, 32'hC);
    ser_send(32'hFFFF_FFFF, 32, 10);
    ser_send(32'h0300_0001, 32, 99);
    idle(12);

    // R10: toggling enable
    cur_req = "R10";
    for (int i = 0; i < 20; i++) begin
      ce = i[0] ^ i[2]; @(negedge clk);
    end
    ce = 1; idle(4);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule